// File: doc/BRIEF.md
# NAND Page Program Sequencer

This block runs one page-program operation on a NAND flash device from a single start pulse. It puts the setup command byte on the flash data bus with the command latch strobe high. It then sends between one and five address bytes with the address latch strobe high. Next it streams the payload bytes and then the auxiliary bytes from two valid/ready sources. It finishes by sending the execute command byte with the command latch strobe high. After that it watches the device ready/busy line. The operation ends with a one-cycle `done` pulse if the device reports ready before a programmable cycle limit runs out, and with a one-cycle `timeout` pulse if it does not.

An enable output for an external ECC encoder is high only while the payload and auxiliary bytes are being written. It is low during the command and address bytes and during the wait. Every byte on the flash bus is framed by an active-low write strobe. The strobe stays low for a programmable number of cycles, then returns high for at least one cycle. The data and both latch strobes are held for the whole low time.

Both data sources follow the same back-pressure rule. A byte moves on a clock edge where `valid` and `ready` are both high. `ready` is high only while the sequencer is in that source's phase and the byte writer is free. When a source holds `valid` low, the sequence stalls and no byte is lost or repeated. All configuration pins are captured on the accepted start pulse. A synchronous ready/busy input is assumed.

Top module: `nand_prog_seq`

## Requirements
- R1: After reset the sequencer is idle: `nand_we_n`=1, and `nand_cle`, `nand_ale`, `ecc_en`, `busy`, `done`, `timeout`, `pay_ready` and `aux_ready` are all 0.
- R2: Bytes go out in this order:
  - `cmd_setup` with CLE=1;
  - `addr_cnt` address bytes with ALE=1, lowest byte `addr_bytes[7:0]` first;
  - `pay_len` payload bytes and then `aux_len` auxiliary bytes, in stream order with CLE=ALE=0;
  - `cmd_exec` with CLE=1.
- R3: For each byte, `nand_we_n` is low for exactly `we_cycles` consecutive cycles (values 1 to 15), and `nand_dq`, `nand_cle` and `nand_ale` stay stable for that whole time. CLE and ALE are never high together.
- R4: `ecc_en` is 1 while each payload and auxiliary byte is strobed. It is 0 while the command and address bytes are strobed and during the ready wait.
- R5: Exactly `pay_len` payload bytes and `aux_len` auxiliary bytes are taken (each 1 to 255). `pay_ready` and `aux_ready` are never high together, and a source holding `valid` low stalls the sequence without losing data.
- R6: With both sources always valid, each byte takes `we_cycles`+2 cycles. The ready wait starts B*(`we_cycles`+2) edges after the edge that accepts start, where B is the total byte count.
- R7: If `nand_rb`=1 is sampled on wait edge k, counting from 1, with k ≤ `busy_limit`, then `done` goes high right after that edge for exactly one cycle. This includes the case where ready arrives on the final allowed edge.
- R8: If `nand_rb` stays 0 for `busy_limit` wait edges, then `timeout` goes high right after edge `busy_limit` for one cycle and `done` stays 0.
- R9: A start pulse while busy is ignored. Configuration pins that change during an operation have no effect on it.
- R10: `busy` is 1 from the edge that accepts start until the edge that raises `done` or `timeout`, where it returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse, accepted only when idle |
| cmd_setup | input | 8 | First command byte |
| cmd_exec | input | 8 | Final command byte |
| addr_cnt | input | 3 | Number of address bytes, 1 to 5 |
| addr_bytes | input | 40 | Address bytes, lowest byte sent first |
| pay_len | input | 8 | Payload byte count, 1 to 255 |
| aux_len | input | 8 | Auxiliary byte count, 1 to 255 |
| we_cycles | input | 4 | Write strobe low time in cycles |
| busy_limit | input | 16 | Ready-wait limit in cycles, at least 1 |
| pay_valid | input | 1 | Payload byte available |
| pay_data | input | 8 | Payload byte |
| pay_ready | output | 1 | Payload byte accepted when high with valid |
| aux_valid | input | 1 | Auxiliary byte available |
| aux_data | input | 8 | Auxiliary byte |
| aux_ready | output | 1 | Auxiliary byte accepted when high with valid |
| nand_rb | input | 1 | Device ready (1) or busy (0) |
| nand_cle | output | 1 | Command latch strobe |
| nand_ale | output | 1 | Address latch strobe |
| nand_we_n | output | 1 | Active-low write strobe |
| nand_dq | output | 8 | Flash data bus |
| ecc_en | output | 1 | ECC encoder enable |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle success pulse |
| timeout | output | 1 | One-cycle timeout pulse |

## Verification
The start edge is edge 0. With both sources always valid, byte k's write strobe falls after edge 1+k*(W+2) and rises after edge 1+k*(W+2)+W. Write E for B*(W+2); the wait begins at edge E. `done` is due right after edge E+D when ready is first driven high for edge E+D. `timeout` is due right after edge E+`busy_limit`. The bench counts clock edges from the accepted start and samples at the falling edge. It checks that the result flag appears exactly at the computed edge and not one edge earlier, and it checks the strobe width and byte order against the computed schedule. Runs with back-pressure on the sources check only order and counts, because their timing depends on the stall pattern.

// File: rtl/nps_pkg.sv
package nps_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE, SQ_SETUP, SQ_ADDR, SQ_PAY, SQ_AUX, SQ_EXEC, SQ_WAIT
  } seq_state_t;

  typedef enum logic [1:0] {
    WR_IDLE, WR_LOW, WR_HIGH
  } wr_state_t;
endpackage

// File: rtl/nps_byte_writer.sv
module nps_byte_writer
  import nps_pkg::*;
#(
  parameter int WE_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            go,
  input  logic [7:0]      byte_in,
  input  logic            cle_in,
  input  logic            ale_in,
  input  logic [WE_W-1:0] low_cycles,
  output logic            free,
  output logic            finished,
  output logic            we_n,
  output logic [7:0]      dq,
  output logic            cle,
  output logic            ale
);
  wr_state_t       st;
  logic [WE_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= WR_IDLE;
      cnt <= '0;
      dq  <= '0;
      cle <= 1'b0;
      ale <= 1'b0;
    end else begin
      unique case (st)
        WR_IDLE: if (go) begin
          st  <= WR_LOW;
          cnt <= '0;
          dq  <= byte_in;
          cle <= cle_in;
          ale <= ale_in;
        end
        WR_LOW: begin
          // zero low time behaves as one cycle
          if ({1'b0, cnt} + 1'b1 >= {1'b0, low_cycles}) st <= WR_HIGH;
          else cnt <= cnt + 1'b1;
        end
        WR_HIGH: begin
          st  <= WR_IDLE;
          cle <= 1'b0;
          ale <= 1'b0;
        end
        default: st <= WR_IDLE;
      endcase
    end
  end

  assign free     = (st == WR_IDLE);
  assign finished = (st == WR_HIGH);
  assign we_n     = (st != WR_LOW);

  // R3: bus and latch strobes hold while the write strobe is low
  a_r3_hold_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n && !$past(we_n)) |-> ($stable(dq) && $stable(cle) && $stable(ale)));
  // R3: never command and address latch at once
  a_r3_latch_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(cle && ale));
endmodule

// File: rtl/nps_wait_timer.sv
module nps_wait_timer #(
  parameter int TO_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            run,
  input  logic [TO_W-1:0] limit,
  output logic            expired
);
  logic [TO_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (run && !expired) cnt <= cnt + 1'b1;
  end

  assign expired = ({1'b0, cnt} + 1'b1 >= {1'b0, limit});
endmodule

// File: rtl/nand_prog_seq.sv
module nand_prog_seq
  import nps_pkg::*;
#(
  parameter int ADDR_MAX = 5,
  parameter int LEN_W    = 8,
  parameter int WE_W     = 4,
  parameter int TO_W     = 16,
  localparam int AC_W    = $clog2(ADDR_MAX + 1),
  localparam int AB_W    = 8 * ADDR_MAX
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [7:0]       cmd_setup,
  input  logic [7:0]       cmd_exec,
  input  logic [AC_W-1:0]  addr_cnt,
  input  logic [AB_W-1:0]  addr_bytes,
  input  logic [LEN_W-1:0] pay_len,
  input  logic [LEN_W-1:0] aux_len,
  input  logic [WE_W-1:0]  we_cycles,
  input  logic [TO_W-1:0]  busy_limit,
  input  logic             pay_valid,
  input  logic [7:0]       pay_data,
  output logic             pay_ready,
  input  logic             aux_valid,
  input  logic [7:0]       aux_data,
  output logic             aux_ready,
  input  logic             nand_rb,
  output logic             nand_cle,
  output logic             nand_ale,
  output logic             nand_we_n,
  output logic [7:0]       nand_dq,
  output logic             ecc_en,
  output logic             busy,
  output logic             done,
  output logic             timeout
);
  seq_state_t       state;
  logic [LEN_W-1:0] cnt;
  logic [7:0]       setup_q, exec_q;
  logic [AC_W-1:0]  acnt_q;
  logic [AB_W-1:0]  addr_q;
  logic [LEN_W-1:0] plen_q, alen_q;
  logic [WE_W-1:0]  we_q;
  logic [TO_W-1:0]  lim_q;

  logic       w_go, w_cle, w_ale, w_free, w_fin;
  logic [7:0] w_byte;
  logic       t_clr, t_exp;
  logic       last_byte;

  // byte source selection for the writer
  always_comb begin
    w_go      = 1'b0;
    w_byte    = '0;
    w_cle     = 1'b0;
    w_ale     = 1'b0;
    pay_ready = 1'b0;
    aux_ready = 1'b0;
    unique case (state)
      SQ_SETUP: begin w_go = w_free; w_byte = setup_q; w_cle = 1'b1; end
      SQ_ADDR: begin
        w_go   = w_free;
        w_byte = 8'(addr_q >> {cnt, 3'b000});
        w_ale  = 1'b1;
      end
      SQ_PAY: begin pay_ready = w_free; w_go = w_free && pay_valid; w_byte = pay_data; end
      SQ_AUX: begin aux_ready = w_free; w_go = w_free && aux_valid; w_byte = aux_data; end
      SQ_EXEC: begin w_go = w_free; w_byte = exec_q; w_cle = 1'b1; end
      default: ;
    endcase
  end

  always_comb begin
    unique case (state)
      SQ_ADDR: last_byte = ({{(LEN_W-AC_W){1'b0}}, acnt_q} <= cnt + 1'b1);
      SQ_PAY:  last_byte = (plen_q <= cnt + 1'b1);
      SQ_AUX:  last_byte = (alen_q <= cnt + 1'b1);
      default: last_byte = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= SQ_IDLE;
      cnt     <= '0;
      setup_q <= '0;
      exec_q  <= '0;
      acnt_q  <= '0;
      addr_q  <= '0;
      plen_q  <= '0;
      alen_q  <= '0;
      we_q    <= '0;
      lim_q   <= '0;
      done    <= 1'b0;
      timeout <= 1'b0;
    end else begin
      done    <= 1'b0;
      timeout <= 1'b0;
      unique case (state)
        SQ_IDLE: if (start) begin
          setup_q <= cmd_setup;
          exec_q  <= cmd_exec;
          acnt_q  <= addr_cnt;
          addr_q  <= addr_bytes;
          plen_q  <= pay_len;
          alen_q  <= aux_len;
          we_q    <= we_cycles;
          lim_q   <= busy_limit;
          cnt     <= '0;
          state   <= SQ_SETUP;
        end
        SQ_SETUP: if (w_fin) state <= SQ_ADDR;
        SQ_ADDR, SQ_PAY, SQ_AUX: if (w_fin) begin
          if (last_byte) begin
            cnt   <= '0;
            state <= (state == SQ_ADDR) ? SQ_PAY :
                     (state == SQ_PAY)  ? SQ_AUX : SQ_EXEC;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        SQ_EXEC: if (w_fin) state <= SQ_WAIT;
        SQ_WAIT: begin
          if (nand_rb) begin
            done  <= 1'b1;
            state <= SQ_IDLE;
          end else if (t_exp) begin
            timeout <= 1'b1;
            state   <= SQ_IDLE;
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  assign t_clr  = (state != SQ_WAIT);
  assign ecc_en = (state == SQ_PAY) || (state == SQ_AUX);
  assign busy   = (state != SQ_IDLE);

  nps_byte_writer #(.WE_W(WE_W)) u_writer (
    .clk(clk), .rst_n(rst_n), .go(w_go), .byte_in(w_byte),
    .cle_in(w_cle), .ale_in(w_ale), .low_cycles(we_q),
    .free(w_free), .finished(w_fin), .we_n(nand_we_n),
    .dq(nand_dq), .cle(nand_cle), .ale(nand_ale)
  );

  nps_wait_timer #(.TO_W(TO_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(t_clr), .run(state == SQ_WAIT),
    .limit(lim_q), .expired(t_exp)
  );

  // R4: encoder enable never overlaps a command or address strobe
  a_r4_ecc_data_only: assert property (@(posedge clk) disable iff (!rst_n)
    ecc_en |-> (!nand_cle && !nand_ale));
  // R5: only one source can be offered a transfer
  a_r5_one_source: assert property (@(posedge clk) disable iff (!rst_n)
    !(pay_ready && aux_ready));
  // R7 / R8: outcomes exclusive and single-cycle
  a_r7_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, timeout}));
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8: a timeout only follows a busy sample
  a_r8_timeout_busy: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> !$past(nand_rb));
  // R10: busy is released together with the outcome
  a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
    (done || timeout) |-> !busy);
endmodule

// File: tb/nand_prog_seq_bench.sv
module nand_prog_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  cmd_setup = 8'h80, cmd_exec = 8'h10;
  logic [2:0]  addr_cnt = 3'd1;
  logic [39:0] addr_bytes = 40'h55_44_33_22_11;
  logic [7:0]  pay_len = 8'd3, aux_len = 8'd2;
  logic [3:0]  we_cycles = 4'd1;
  logic [15:0] busy_limit = 16'd10;
  logic        pay_valid, aux_valid, pay_ready, aux_ready;
  logic [7:0]  pay_data, aux_data;
  logic        nand_rb = 1'b1;
  logic        nand_cle, nand_ale, nand_we_n, ecc_en, busy, done, timeout;
  logic [7:0]  nand_dq;

  always #5 clk = ~clk;

  nand_prog_seq u_nand_prog_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_setup(cmd_setup),
    .cmd_exec(cmd_exec), .addr_cnt(addr_cnt), .addr_bytes(addr_bytes),
    .pay_len(pay_len), .aux_len(aux_len), .we_cycles(we_cycles),
    .busy_limit(busy_limit), .pay_valid(pay_valid), .pay_data(pay_data),
    .pay_ready(pay_ready), .aux_valid(aux_valid), .aux_data(aux_data),
    .aux_ready(aux_ready), .nand_rb(nand_rb), .nand_cle(nand_cle),
    .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_dq(nand_dq),
    .ecc_en(ecc_en), .busy(busy), .done(done), .timeout(timeout)
  );

  int checks = 0, errors = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // sources: data is a function of the index taken so far
  int  p_idx = 0, a_idx = 0;
  logic src_clr = 1'b0, gap = 1'b0, gate = 1'b1;
  always @(posedge clk) begin
    if (src_clr) begin p_idx <= 0; a_idx <= 0; end
    else begin
      if (pay_valid && pay_ready) p_idx <= p_idx + 1;
      if (aux_valid && aux_ready) a_idx <= a_idx + 1;
    end
  end
  always @(negedge clk) gate <= gap ? ((cyc % 3) != 0) : 1'b1;
  assign pay_valid = gate;
  assign aux_valid = gap ? !gate : 1'b1;
  assign pay_data  = 8'(8'hA0 + p_idx * 7);
  assign aux_data  = 8'(8'h30 + a_idx * 5);

  // expected byte schedule
  logic [7:0] ex_b [32];
  logic       ex_c [32], ex_a [32], ex_e [32];
  int n_exp = 0;

  // bus monitor
  int mon_n = 0, bad_ord = 0, bad_w = 0, bad_ecc = 0, bad_hold = 0, lowcnt = 0, cur_w = 1;
  logic [7:0] cap_dq;
  logic cap_c, cap_a, cap_e;
  always @(negedge clk) begin
    if (rst_n && !nand_we_n) begin
      if (lowcnt == 0) begin
        cap_dq = nand_dq; cap_c = nand_cle; cap_a = nand_ale; cap_e = ecc_en;
      end else if (nand_dq != cap_dq || nand_cle != cap_c || nand_ale != cap_a)
        bad_hold++;
      lowcnt++;
    end else if (lowcnt != 0) begin
      if (mon_n >= n_exp || cap_dq != ex_b[mon_n] || cap_c != ex_c[mon_n] || cap_a != ex_a[mon_n])
        bad_ord++;
      if (mon_n < n_exp && cap_e != ex_e[mon_n]) bad_ecc++;
      if (lowcnt != cur_w) bad_w++;
      mon_n++;
      lowcnt = 0;
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push(logic [7:0] b, logic c, logic a, logic e);
    ex_b[n_exp] = b; ex_c[n_exp] = c; ex_a[n_exp] = a; ex_e[n_exp] = e;
    n_exp++;
  endtask

  // one operation; rb raised to be sampled on wait edge d; d > l means timeout
  task automatic run(int w, int na, int np, int nx, int l, int d, bit use_gap, bit poke);
    int s, e0, fin, tmo, guard;
    bit raised;
    @(negedge clk);
    we_cycles = 4'(w); addr_cnt = 3'(na); pay_len = 8'(np); aux_len = 8'(nx);
    busy_limit = 16'(l); gap = use_gap; cur_w = w;
    n_exp = 0; mon_n = 0; bad_ord = 0; bad_w = 0; bad_ecc = 0; bad_hold = 0;
    push(cmd_setup, 1, 0, 0);
    for (int i = 0; i < na; i++) push(addr_bytes[8*i +: 8], 0, 1, 0);
    for (int i = 0; i < np; i++) push(8'(8'hA0 + i * 7), 0, 0, 1);
    for (int i = 0; i < nx; i++) push(8'(8'h30 + i * 5), 0, 0, 1);
    push(cmd_exec, 1, 0, 0);
    src_clr = 1'b1;
    @(negedge clk);
    src_clr = 1'b0;
    nand_rb = 1'b0;
    start = 1'b1;
    s = cyc;
    e0 = s + 1;
    @(negedge clk);
    start = 1'b0;
    check("R10 busy after start", busy, 1);
    fin = e0 + n_exp * (w + 2) + ((d > l) ? l : d);
    tmo = 0; guard = 0; raised = 0;
    while (!(done || timeout) && guard < 5000) begin
      if (poke && cyc == e0 + 4) begin start = 1'b1; cmd_setup = 8'hEE; addr_cnt = 3'd2; end
      else start = 1'b0;
      if (!use_gap && !raised && cyc == fin - 1 && d <= l) begin nand_rb = 1'b1; raised = 1; end
      if (use_gap && !busy) guard = 5000;
      @(negedge clk);
      guard++;
      if (!use_gap && cyc == fin - 1) check("R6 no early outcome", int'(done || timeout), 0);
      if (use_gap && !raised && !u_nand_prog_seq.nand_we_n && mon_n == n_exp - 1) ;
      if (use_gap && !raised && mon_n == n_exp) begin nand_rb = 1'b1; raised = 1; end
    end
    start = 1'b0;
    if (guard >= 5000) begin errors++; $display("FAIL watchdog R10 actual=hung expected=finish"); end
    if (!use_gap) begin
      check("R6/R7/R8 outcome edge", cyc, fin);
      if (d > l) begin
        check("R8 timeout flag", timeout, 1);
        check("R8 no done", done, 0);
      end else begin
        check("R7 done flag", done, 1);
        check("R7 no timeout", timeout, 0);
      end
    end else check("R5 done after stalls", done, 1);
    check("R10 busy released", busy, 0);
    check("R2 byte order", bad_ord, 0);
    check("R2 byte count", mon_n, n_exp);
    check("R3 strobe width", bad_w, 0);
    check("R3 hold while low", bad_hold, 0);
    check("R4 ecc phase", bad_ecc, 0);
    check("R5 payload taken", p_idx, np);
    check("R5 aux taken", a_idx, nx);
    @(negedge clk);
    check("R7 single pulse", int'(done || timeout), 0);
    check("R4 ecc off when idle", ecc_en, 0);
    cmd_setup = 8'h80;
    nand_rb = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 we_n", nand_we_n, 1);
    check("R1 strobes", int'({nand_cle, nand_ale, ecc_en}), 0);
    check("R1 status", int'({busy, done, timeout}), 0);
    check("R1 ready", int'({pay_ready, aux_ready}), 0);
    rst_n = 1'b1;
    // sweep strobe width and address count
    for (int w = 1; w <= 3; w++)
      for (int a = 1; a <= 5; a++)
        run(w, a, 3, 2, 10, 1 + (a % 4), 1'b0, 1'b0);
    // R7 ready on the last allowed wait edge wins
    run(2, 3, 2, 1, 6, 6, 1'b0, 1'b0);
    // R8 ready one edge too late
    run(2, 3, 2, 1, 6, 7, 1'b0, 1'b0);
    // R8 limit of one
    run(1, 1, 1, 1, 1, 2, 1'b0, 1'b0);
    // R9 start and config changes while busy are ignored
    run(2, 4, 3, 2, 10, 3, 1'b0, 1'b1);
    // R5 back-pressure on both sources
    run(1, 2, 4, 3, 10, 1, 1'b1, 1'b0);
    run(3, 5, 4, 3, 10, 1, 1'b1, 1'b0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog R10 actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule